// File: doc/BRIEF.md
# Per-Page Hit/Miss Event Counters

This block sits beside a DDR SDRAM controller and keeps statistics on how well that controller's open-page policy performs. Each clock cycle the controller's page-management logic may present one packed event word. The word carries a valid flag, a hit/miss flag and the index of one of eight open-page slots. The block decodes the word into one increment for exactly one of sixteen counters. There is a hit counter and a miss counter for every page slot.

Software-facing control is kept minimal. A level enable freezes or runs all counters together. A single-cycle clear strobe wipes every counter and every overflow flag. A read port returns any one counter, chosen by a small index, one cycle after the request. Counters saturate rather than wrap. A sticky per-counter overflow flag records that an increment was lost.

A two-state controller holds the run/freeze mode. In state `ST_FROZEN` no increment is applied. Transition `ARM` (enable sampled high) moves it to `ST_COUNTING`, where increments are applied. Transition `HALT` (enable sampled low) returns it to `ST_FROZEN`. Both states otherwise hold. The page count must be a power of two.

Top module: `pgc_page_event_counters`

## Requirements
- R1: After reset every counter reads zero, every overflow flag is 0, `rd_valid_o`, `rd_data_o` and `rd_ovf_o` are 0, and the controller is in `ST_FROZEN`.
- R2: While counting, an event word with bit 4 = 1 adds one to exactly one counter. The counter index is {bit 3, bits 2:0}: bit 3 = 1 selects the hit counter, bit 3 = 0 selects the miss counter, and bits 2:0 give the page. All other counters are unchanged.
- R3: An event word with bit 4 = 0 changes no counter and no flag.
- R4: The enable is registered. An event is counted only when `count_en_i` was 1 at the previous clock edge. Enable going high arms counting from the next cycle, and enable going low freezes all counters from the next cycle.
- R5: A counter at all-ones stays at all-ones when it receives another increment. It never wraps.
- R6: An increment that arrives at a counter already at all-ones sets that counter's overflow flag. The flag stays set until a clear or a reset.
- R7: `clear_i` = 1 zeroes all counters and all overflow flags at the next edge. An event in the same cycle is discarded.
- R8: A cycle with `rd_req_i` = 1 makes `rd_valid_o` = 1 in the following cycle. In that cycle `rd_data_o` holds the counter selected by `rd_sel_i`, using the same {hit, page} index as R2, and `rd_ovf_o` holds that counter's flag. Both values are taken before any update at that edge. Without a request, `rd_valid_o` is 0 in the next cycle.
- R9: Bit k of `ovf_flags_o` is the overflow flag of counter k. Miss counters are at k = page and hit counters are at k = 8 + page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| count_en_i | input | 1 | Level enable; low freezes all counters |
| clear_i | input | 1 | One-cycle strobe zeroing counters and flags |
| event_i | input | 5 | Event word: [4] valid, [3] hit, [2:0] page |
| rd_req_i | input | 1 | Read request |
| rd_sel_i | input | 4 | Counter index {hit, page} |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 32 | Selected counter value |
| rd_ovf_o | output | 1 | Overflow flag of the selected counter |
| ovf_flags_o | output | 16 | All overflow flags, indexed as in R9 |

## Verification
The bench builds the block with narrow counters so that saturation is reached in a few cycles. It checks that a counter stalls at all-ones and that its overflow flag appears on the lost increment. A wrapping counter would read back a small value, and a flag raised too early would show up in the flag vector a cycle ahead of the model. Events are sent in the same cycle that the enable rises and in the cycle after it falls. A controller that applied the enable without registering it would count one extra event or drop one. A clear is issued together with a valid event, which exposes a design that lets the event win. Reads are issued in the same cycle as events to the same counter, so a read path that forwards the new value returns one too many. Hit and miss events to the same page are interleaved so that a swapped hit/miss bit shows up.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    // Run/freeze mode of the counter bank.
    typedef enum logic [0:0] {
        ST_FROZEN   = 1'b0,
        ST_COUNTING = 1'b1
    } pgc_state_e;

endpackage

// File: rtl/pgc_ctrl_fsm.sv
module pgc_ctrl_fsm
    import pgc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic count_en_i,
    output logic count_allow_o
);

    pgc_state_e state_q, state_d;

    // Next-state logic: ARM and HALT transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FROZEN:   if (count_en_i)  state_d = ST_COUNTING; // ARM
            ST_COUNTING: if (!count_en_i) state_d = ST_FROZEN;   // HALT
            default:     state_d = ST_FROZEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_FROZEN;
        else         state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        count_allow_o = 1'b0;
        unique case (state_q)
            ST_FROZEN:   count_allow_o = 1'b0;
            ST_COUNTING: count_allow_o = 1'b1;
            default:     count_allow_o = 1'b0;
        endcase
    end

    // A low enable must leave the bank frozen in the next cycle.
    assert_freeze_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !count_en_i |=> (state_q == ST_FROZEN));

    // A high enable must arm counting in the next cycle.
    assert_arm_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_en_i |=> (state_q == ST_COUNTING));

endmodule

// File: rtl/pgc_event_decode.sv
module pgc_event_decode #(
    parameter int unsigned NUM_PAGES = 8,
    localparam int unsigned PAGE_W  = $clog2(NUM_PAGES),
    localparam int unsigned SEL_W   = PAGE_W + 1,
    localparam int unsigned EV_W    = PAGE_W + 2,
    localparam int unsigned NUM_CNT = 2 * NUM_PAGES
) (
    input  logic [EV_W-1:0]    event_i,
    input  logic               allow_i,
    input  logic               clear_i,
    output logic [NUM_CNT-1:0] inc_o
);

    logic             ev_valid;
    logic [SEL_W-1:0] ev_idx;

    // Valid is the top bit; the hit flag and page form the counter index.
    assign ev_valid = event_i[EV_W-1];
    assign ev_idx   = event_i[SEL_W-1:0];

    // Clear beats any event in the same cycle.
    always_comb begin
        inc_o = '0;
        if (ev_valid && allow_i && !clear_i) begin
            inc_o[ev_idx] = 1'b1;
        end
    end

endmodule

// File: rtl/pgc_counter_cell.sv
module pgc_counter_cell #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic             at_max;

    assign at_max = (count_q == CNT_MAX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (clear_i) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (inc_i) begin
            if (at_max) ovf_q   <= 1'b1;          // increment lost
            else        count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;
    assign ovf_o   = ovf_q;

    assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (at_max && inc_i && !clear_i) |=> (count_q == CNT_MAX));

    assert_ovf_on_lost_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (at_max && inc_i && !clear_i) |=> ovf_q);

    assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_q && !clear_i) |=> ovf_q);

    assert_clear_zeroes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (count_q == '0 && !ovf_q));

    assert_idle_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_i && !clear_i) |=> ($stable(count_q) && $stable(ovf_q)));

endmodule

// File: rtl/pgc_page_event_counters.sv
module pgc_page_event_counters #(
    parameter int unsigned NUM_PAGES = 8,
    parameter int unsigned CNT_W     = 32,
    localparam int unsigned PAGE_W   = $clog2(NUM_PAGES),
    localparam int unsigned SEL_W    = PAGE_W + 1,
    localparam int unsigned EV_W     = PAGE_W + 2,
    localparam int unsigned NUM_CNT  = 2 * NUM_PAGES
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               count_en_i,
    input  logic               clear_i,
    input  logic [EV_W-1:0]    event_i,
    input  logic               rd_req_i,
    input  logic [SEL_W-1:0]   rd_sel_i,
    output logic               rd_valid_o,
    output logic [CNT_W-1:0]   rd_data_o,
    output logic               rd_ovf_o,
    output logic [NUM_CNT-1:0] ovf_flags_o
);

    logic               count_allow;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
    logic [NUM_CNT-1:0] ovf_vec;

    pgc_ctrl_fsm u_ctrl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .count_en_i    (count_en_i),
        .count_allow_o (count_allow)
    );

    pgc_event_decode #(
        .NUM_PAGES (NUM_PAGES)
    ) u_decode (
        .event_i (event_i),
        .allow_i (count_allow),
        .clear_i (clear_i),
        .inc_o   (inc_vec)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cell
        pgc_counter_cell #(
            .CNT_W (CNT_W)
        ) u_cell (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clear_i (clear_i),
            .inc_i   (inc_vec[k]),
            .count_o (cnt_arr[k]),
            .ovf_o   (ovf_vec[k])
        );
    end

    assign ovf_flags_o = ovf_vec;

    // Registered read port: values taken before this edge's update.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            rd_ovf_o   <= 1'b0;
        end else begin
            rd_valid_o <= rd_req_i;
            if (rd_req_i) begin
                rd_data_o <= cnt_arr[rd_sel_i];
                rd_ovf_o  <= ovf_vec[rd_sel_i];
            end
        end
    end

    assert_single_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(inc_vec));

    assert_inc_needs_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_vec != '0) |-> event_i[EV_W-1]);

    assert_read_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_i |=> rd_valid_o);

    assert_read_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_req_i |=> !rd_valid_o);

endmodule

// File: tb/pgc_page_event_counters_tb_top.sv
module pgc_page_event_counters_tb_top;

    localparam int unsigned NP   = 8;
    localparam int unsigned CW   = 4;
    localparam int unsigned NC   = 2 * NP;
    localparam logic [CW-1:0] MAXV = '1;

    typedef struct {
        logic [3:0]    sel;
        logic [CW-1:0] data;
        logic          ovf;
        string         tag;
    } rd_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          clr = 1'b0;
    logic [4:0]    ev = '0;
    logic          rreq = 1'b0;
    logic [3:0]    rsel = '0;
    logic          rvalid;
    logic [CW-1:0] rdata;
    logic          rovf;
    logic [NC-1:0] oflags;

    int errors = 0;
    int checks = 0;

    logic [CW-1:0] m_cnt [NC];
    logic [NC-1:0] m_ovf;
    logic          m_run;
    rd_item_t      exp_q [$];

    always #2 clk = ~clk;

    pgc_page_event_counters #(
        .NUM_PAGES (NP),
        .CNT_W     (CW)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .count_en_i  (en),
        .clear_i     (clr),
        .event_i     (ev),
        .rd_req_i    (rreq),
        .rd_sel_i    (rsel),
        .rd_valid_o  (rvalid),
        .rd_data_o   (rdata),
        .rd_ovf_o    (rovf),
        .ovf_flags_o (oflags)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, model update, then flag-vector check.
    task automatic step(input logic e, input logic c, input logic [4:0] w,
                        input logic rq, input logic [3:0] s, input string tag);
        rd_item_t it;
        @(negedge clk);
        en = e; clr = c; ev = w; rreq = rq; rsel = s;
        if (rq) begin
            it.sel = s; it.data = m_cnt[s]; it.ovf = m_ovf[s]; it.tag = tag;
            exp_q.push_back(it);
        end
        if (c) begin
            for (int k = 0; k < NC; k++) m_cnt[k] = '0;
            m_ovf = '0;
        end else if (m_run && w[4]) begin
            if (m_cnt[w[3:0]] == MAXV) m_ovf[w[3:0]] = 1'b1;
            else m_cnt[w[3:0]] = m_cnt[w[3:0]] + 1'b1;
        end
        m_run = e;
        @(posedge clk);
        #1;
        check(oflags == m_ovf, {tag, " R9 flags"}, 32'(oflags), 32'(m_ovf));
    endtask

    task automatic read_all(input logic e, input string tag);
        for (int k = 0; k < NC; k++) step(e, 1'b0, 5'b0, 1'b1, 4'(k), tag);
        step(e, 1'b0, 5'b0, 1'b0, 4'd0, tag);
    endtask

    // Monitor: pops expected read results as the design presents them.
    always @(posedge clk) begin
        #1;
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected rd_valid", 32'(rvalid), 32'd0);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(rdata == it.data, $sformatf("%s data sel=%0d", it.tag, it.sel),
                      32'(rdata), 32'(it.data));
                check(rovf == it.ovf, $sformatf("%s ovf sel=%0d", it.tag, it.sel),
                      32'(rovf), 32'(it.ovf));
            end
        end
    end

    initial begin
        #400000;
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NC; k++) m_cnt[k] = '0;
        m_ovf = '0;
        m_run = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(rvalid == 1'b0, "R1 rd_valid", 32'(rvalid), 32'd0);
        check(rdata == '0, "R1 rd_data", 32'(rdata), 32'd0);
        check(rovf == 1'b0, "R1 rd_ovf", 32'(rovf), 32'd0);
        check(oflags == '0, "R1 flags", 32'(oflags), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R4: frozen after reset, valid events must not count
        step(1'b0, 1'b0, 5'b11010, 1'b0, 4'd0, "R4 frozen");
        step(1'b0, 1'b0, 5'b10001, 1'b0, 4'd0, "R4 frozen");
        read_all(1'b0, "R1 R4 zero");

        // R4: event in the cycle enable rises is not counted
        step(1'b1, 1'b0, 5'b11111, 1'b0, 4'd0, "R4 arm edge");
        // R2: hits and misses interleaved on the same pages
        step(1'b1, 1'b0, 5'b11011, 1'b0, 4'd0, "R2 hit p3");
        step(1'b1, 1'b0, 5'b10011, 1'b0, 4'd0, "R2 miss p3");
        step(1'b1, 1'b0, 5'b11011, 1'b0, 4'd0, "R2 hit p3");
        step(1'b1, 1'b0, 5'b10000, 1'b0, 4'd0, "R2 miss p0");
        step(1'b1, 1'b0, 5'b11111, 1'b0, 4'd0, "R2 hit p7");
        // R3: invalid words with every other pattern
        step(1'b1, 1'b0, 5'b01011, 1'b0, 4'd0, "R3 invalid");
        step(1'b1, 1'b0, 5'b00110, 1'b0, 4'd0, "R3 invalid");
        // R8: read in the same cycle as an event to that counter
        step(1'b1, 1'b0, 5'b11011, 1'b1, 4'd11, "R8 same-cycle");
        step(1'b1, 1'b0, 5'b00000, 1'b1, 4'd11, "R8 after");
        read_all(1'b1, "R2 R3 counts");

        // R4: enable low; the event in that cycle still counts, the next does not
        step(1'b0, 1'b0, 5'b10101, 1'b0, 4'd0, "R4 halt edge");
        step(1'b0, 1'b0, 5'b10101, 1'b0, 4'd0, "R4 halted");
        step(1'b0, 1'b0, 5'b0, 1'b1, 4'd5, "R4 halt read");

        // R5/R6: saturate the hit counter of page 5
        step(1'b1, 1'b0, 5'b0, 1'b0, 4'd0, "R5 arm");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 5'b11101, 1'b0, 4'd0, "R5 R6 saturate");
        step(1'b1, 1'b0, 5'b0, 1'b1, 4'd13, "R5 R6 read");
        step(1'b1, 1'b0, 5'b0, 1'b0, 4'd0, "R6 hold");
        check(oflags[13] == 1'b1, "R9 flag bit13", 32'(oflags[13]), 32'd1);
        read_all(1'b1, "R5 R6 all");

        // R7: clear with a simultaneous valid event
        step(1'b1, 1'b1, 5'b11101, 1'b0, 4'd0, "R7 clear wins");
        check(oflags == '0, "R7 flags cleared", 32'(oflags), 32'd0);
        read_all(1'b1, "R7 zero");
        step(1'b1, 1'b0, 5'b10010, 1'b0, 4'd0, "R7 after clear");
        read_all(1'b0, "R7 restart");

        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R8 pending reads", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule